// File: doc/BRIEF.md
# Flash Control Register Bank

This block is the bus-slave register bank that sits in front of an on-chip flash controller. It holds four byte-wide control registers at byte offsets 0 to 3 and one halfword emulation register at a separate, parameterised offset. A requester raises `req` with the address, size, direction and write data, and holds them until `ack`. The block inserts a fixed number of wait cycles that depends on the target register and the access size. It returns read data in the single cycle when `ack` is high. Illegal accesses finish with the same handshake and change nothing. In that case `err` pulses alongside `ack`.

Writes to the byte registers are allowed only when the external write-enable pin is high. Bit 7 of the first control register mirrors that pin, so this register resets to 0x80 or to 0x00 depending on the pin level. Bit 6 of the same register is a software enable. The two erase-block registers are held at zero unless both the pin and bit 6 are high. A mode input can mark the on-chip ROM as disabled. While it does, the byte registers read as zero and ignore writes. The emulation register is not affected by the pin or the mode input.

Top module: `flash_ctl_regs`

## Requirements
- R1: Offsets 0, 1, 2 and 3 select control-1, control-2, erase-block-1 and erase-block-2. The emulation register answers at EMU_OFS (default 0x470). A byte access there selects bits 15:8, and a byte access at EMU_OFS+1 selects bits 7:0. The `size` encoding is 0 = byte, 1 = halfword, 2 = longword, 3 = reserved. Byte and halfword data use the low lanes of `wdata` and `rdata`.
- R2: Every access except a longword access to the emulation register completes with `ack` in the third cycle, counting the cycle in which `req` is first seen as the first.
- R3: A longword access to the emulation register completes with `ack` in the sixth cycle. Its read data is the register in bits 31:16, with zero in bits 15:0.
- R4: `ack` is high for exactly one cycle per accepted request. `rdata` is valid in that cycle and is zero in every other cycle. A request still held during its `ack` cycle is not accepted a second time.
- R5: While `rom_off` is 1, reads of the four byte registers return 0x00 and writes to them have no effect.
- R6: Writes to control-1, erase-block-1 and erase-block-2 take effect only while `fwe_pin` is 1.
- R7: Bit 7 of control-1 always reads as the current `fwe_pin` level, so control-1 reads 0x80 after reset with the pin high and 0x00 with the pin low.
- R8: Both erase-block registers read 0x00 and are cleared while `fwe_pin` is 0 or control-1 bit 6 is 0. They do not return to their old value when the enables come back.
- R9: The emulation register resets to 0x0000. It accepts byte, halfword and valid longword writes whatever the state of `fwe_pin` and `rom_off`. A longword write stores `wdata[31:16]`.
- R10: An error completes with `err` high in the `ack` cycle, changes no state and returns zero read data. The error cases are: any non-byte access to offsets 0 to 3 or EMU_OFS+1, a reserved size, an unmapped address, and a longword write to the emulation register with nonzero `wdata[15:0]`.
- R11: Control-1 bits 6:0 are plain storage. Writes to bit 7 are ignored.
- R12: Control-2 is read-only and always reads 0x00. Writes to it complete without error and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwe_pin | input | 1 | External flash write-enable level |
| rom_off | input | 1 | Operating mode: on-chip ROM disabled |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address within the bank |
| size | input | 2 | Access size code |
| wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle completion strobe |
| err | output | 1 | Error flag, valid with ack |
| rdata | output | 32 | Read data, valid with ack |

## Verification
Assertions check several properties on every cycle. They check that `ack` never lasts two cycles and that `err` and nonzero `rdata` appear only with `ack`. They check that each handshake lasts the latency chosen at acceptance. They check that the erase-block registers drop to zero the cycle after either enable is removed, and that the disabled-ROM mode and idle cycles leave register contents unchanged. The bench scenarios cover the rest: the actual register values seen through reads, the pin-dependent reset value, the lane mapping of the emulation register, and the fact that cleared erase blocks stay cleared.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int DATA_W = 32;
    localparam int REG_W  = 8;
    localparam int EMU_W  = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TG_CTL1 = 3'd0,
        TG_CTL2 = 3'd1,
        TG_EB1  = 3'd2,
        TG_EB2  = 3'd3,
        TG_EMU  = 3'd4,
        TG_NONE = 3'd5
    } target_e;

    typedef struct packed {
        target_e tgt;
        logic    lo_byte;
        logic    bad;
        logic    long_acc;
    } dec_t;

    typedef struct packed {
        dec_t              dec;
        logic              we;
        acc_size_e         size;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic target_e small_target(input logic [1:0] ofs);
        case (ofs)
            2'd0:    return TG_CTL1;
            2'd1:    return TG_CTL2;
            2'd2:    return TG_EB1;
            default: return TG_EB2;
        endcase
    endfunction

    function automatic logic is_byte_reg(input target_e t);
        return (t == TG_CTL1) || (t == TG_CTL2) || (t == TG_EB1) || (t == TG_EB2);
    endfunction

endpackage

// File: rtl/fcr_decode.sv
module fcr_decode
    import fcr_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int unsigned EMU_OFS = 'h470
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] EMU_HI = ADDR_W'(EMU_OFS);
    localparam logic [ADDR_W-1:0] EMU_LO = ADDR_W'(EMU_OFS + 1);

    always_comb begin
        dec = '{tgt: TG_NONE, lo_byte: 1'b0, bad: 1'b1, long_acc: 1'b0};
        if (addr[ADDR_W-1:2] == '0) begin
            dec.tgt = small_target(addr[1:0]);
            dec.bad = (size != SZ_BYTE);
        end else if (addr == EMU_HI) begin
            dec.tgt      = TG_EMU;
            dec.long_acc = (size == SZ_LONG);
            dec.bad      = (size == SZ_RSVD) ||
                           ((size == SZ_LONG) && we && (wdata[EMU_W-1:0] != '0));
        end else if (addr == EMU_LO) begin
            dec.tgt     = TG_EMU;
            dec.lo_byte = 1'b1;
            dec.bad     = (size != SZ_BYTE);
        end
    end
endmodule

// File: rtl/fcr_wait.sv
module fcr_wait #(
    parameter int SHORT_WAIT = 3,
    parameter int LONG_WAIT  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_acc,
    output logic busy,
    output logic last,
    output logic done
);
    localparam int CNT_W = $clog2(LONG_WAIT + 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_WAIT - 3);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_WAIT - 3);

    logic [CNT_W-1:0] cnt_q;

    assign last = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= long_acc ? LONG_LD : SHORT_LD;
            end else if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // checker: cycles elapsed since acceptance versus the expected latency
    logic [CNT_W-1:0] ck_cnt, ck_exp;
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_cnt <= '0;
            ck_exp <= '0;
        end else if (start) begin
            ck_cnt <= CNT_W'(1);
            ck_exp <= long_acc ? CNT_W'(LONG_WAIT - 1) : CNT_W'(SHORT_WAIT - 1);
        end else if (busy) begin
            ck_cnt <= ck_cnt + 1'b1;
        end
    end

    // R2 / R3: handshake length matches the latency chosen at acceptance
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (ck_cnt == ck_exp));

    // R4: no new request is taken while one is in flight
    a_r4_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/fcr_regfile.sv
module fcr_regfile
    import fcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fwe_pin,
    input  logic              rom_off,
    input  logic              commit,
    input  target_e           tgt,
    input  logic              lo_byte,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SWE_BIT = 6;

    logic [REG_W-2:0] ctl1_st;
    logic [REG_W-1:0] eb1_q, eb2_q;
    logic [EMU_W-1:0] emu_q;
    logic             eb_open, byte_wr_ok;

    assign eb_open    = fwe_pin && ctl1_st[SWE_BIT];
    assign byte_wr_ok = commit && fwe_pin && !rom_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1_st <= '0;
        end else if (byte_wr_ok && tgt == TG_CTL1) begin
            ctl1_st <= wdata[REG_W-2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !eb_open) begin
            eb1_q <= '0;
            eb2_q <= '0;
        end else if (byte_wr_ok) begin
            if (tgt == TG_EB1) eb1_q <= wdata[REG_W-1:0];
            if (tgt == TG_EB2) eb2_q <= wdata[REG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            emu_q <= '0;
        end else if (commit && tgt == TG_EMU) begin
            case (size)
                SZ_BYTE: begin
                    if (lo_byte) emu_q[7:0]  <= wdata[7:0];
                    else         emu_q[15:8] <= wdata[7:0];
                end
                SZ_HALF: emu_q <= wdata[EMU_W-1:0];
                SZ_LONG: emu_q <= wdata[DATA_W-1:DATA_W-EMU_W];
                default: emu_q <= emu_q;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (is_byte_reg(tgt) && !rom_off) begin
            case (tgt)
                TG_CTL1: rd_data[REG_W-1:0] = {fwe_pin, ctl1_st};
                TG_EB1:  rd_data[REG_W-1:0] = eb_open ? eb1_q : '0;
                TG_EB2:  rd_data[REG_W-1:0] = eb_open ? eb2_q : '0;
                default: rd_data = '0;
            endcase
        end else if (tgt == TG_EMU) begin
            case (size)
                SZ_BYTE: rd_data[7:0] = lo_byte ? emu_q[7:0] : emu_q[15:8];
                SZ_HALF: rd_data[EMU_W-1:0] = emu_q;
                SZ_LONG: rd_data[DATA_W-1:DATA_W-EMU_W] = emu_q;
                default: rd_data = '0;
            endcase
        end
    end

    // R8: erase blocks are cleared the cycle after either enable is missing
    a_r8_eb_cleared: assert property (@(posedge clk) disable iff (rst)
        (!fwe_pin || !ctl1_st[SWE_BIT]) |=> (eb1_q == '0 && eb2_q == '0));

    // R5: disabled-ROM mode leaves control-1 storage untouched
    a_r5_rom_off_frozen: assert property (@(posedge clk) disable iff (rst)
        (!rst && rom_off) |=> $stable(ctl1_st));

    // R9: emulation register only changes on a committed write
    a_r9_emu_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!rst && !commit) |=> $stable(emu_q));

    // R6: with the pin low, no write reaches control-1 storage
    a_r6_pin_gate: assert property (@(posedge clk) disable iff (rst)
        (!rst && !fwe_pin) |=> $stable(ctl1_st));
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import fcr_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int unsigned EMU_OFS    = 'h470,
    parameter int          SHORT_WAIT = 3,
    parameter int          LONG_WAIT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwe_pin,
    input  logic              rom_off,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    dec_t              dec_now;
    req_t              rq_q;
    logic              busy, last, start, commit;
    logic [DATA_W-1:0] rd_val;

    fcr_decode #(
        .ADDR_W  (ADDR_W),
        .EMU_OFS (EMU_OFS)
    ) u_dec (
        .addr  (addr),
        .size  (acc_size_e'(size)),
        .we    (we),
        .wdata (wdata),
        .dec   (dec_now)
    );

    assign start = req && !busy && !ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_q <= '0;
        end else if (start) begin
            rq_q.dec   <= dec_now;
            rq_q.we    <= we;
            rq_q.size  <= acc_size_e'(size);
            rq_q.wdata <= wdata;
        end
    end

    fcr_wait #(
        .SHORT_WAIT (SHORT_WAIT),
        .LONG_WAIT  (LONG_WAIT)
    ) u_wait (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .long_acc (dec_now.long_acc),
        .busy     (busy),
        .last     (last),
        .done     (ack)
    );

    assign commit = last && rq_q.we && !rq_q.dec.bad;

    fcr_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .fwe_pin (fwe_pin),
        .rom_off (rom_off),
        .commit  (commit),
        .tgt     (rq_q.dec.tgt),
        .lo_byte (rq_q.dec.lo_byte),
        .size    (rq_q.size),
        .wdata   (rq_q.wdata),
        .rd_data (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            err   <= last && rq_q.dec.bad;
            rdata <= (last && !rq_q.we && !rq_q.dec.bad) ? rd_val : '0;
        end
    end

    // R4: acknowledge is a single-cycle pulse
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R10: error flag only accompanies an acknowledge
    a_r10_err_with_ack: assert property (@(posedge clk) disable iff (rst)
        err |-> ack);

    // R4: read data bus is quiet outside the acknowledge cycle
    a_r4_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !ack |-> (rdata == '0));
endmodule

// File: tb/flash_ctl_regs_bench.sv
module flash_ctl_regs_bench;
    localparam int EMU = 'h470;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fwe_pin = 1'b1;
    logic        rom_off = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic        ack, err;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;

    // behavioural model state
    int m_ctl1;
    int m_eb1, m_eb2;
    int m_emu;

    always #2 clk = ~clk;

    flash_ctl_regs u_flash_ctl_regs (
        .clk(clk), .rst(rst), .fwe_pin(fwe_pin), .rom_off(rom_off),
        .req(req), .we(we), .addr(addr), .size(size), .wdata(wdata),
        .ack(ack), .err(err), .rdata(rdata)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic bit eb_on();
        return fwe_pin && ((m_ctl1 >> 6) & 1);
    endfunction

    function automatic void model_settle();
        if (!eb_on()) begin
            m_eb1 = 0;
            m_eb2 = 0;
        end
    endfunction

    function automatic bit model_err(input bit w, input int a, input int sz, input int d);
        if (a >= 0 && a < 4) return sz != 0;
        if (a == EMU) return (sz == 3) || (sz == 2 && w && (d & 'hFFFF) != 0);
        if (a == EMU + 1) return sz != 0;
        return 1;
    endfunction

    function automatic int model_read(input int a, input int sz);
        if (a < 4) begin
            if (rom_off) return 0;
            if (a == 0) return (fwe_pin ? 'h80 : 0) | m_ctl1;
            if (a == 2) return eb_on() ? m_eb1 : 0;
            if (a == 3) return eb_on() ? m_eb2 : 0;
            return 0;
        end
        if (a == EMU + 1) return m_emu & 'hFF;
        if (sz == 0) return (m_emu >> 8) & 'hFF;
        if (sz == 1) return m_emu;
        return m_emu << 16;
    endfunction

    function automatic void model_write(input int a, input int sz, input int d);
        if (a < 4) begin
            if (rom_off || !fwe_pin) return;
            if (a == 0) m_ctl1 = d & 'h7F;
            else if (a == 2 && eb_on()) m_eb1 = d & 'hFF;
            else if (a == 3 && eb_on()) m_eb2 = d & 'hFF;
        end else if (a == EMU + 1) begin
            m_emu = (m_emu & 'hFF00) | (d & 'hFF);
        end else if (sz == 0) begin
            m_emu = (m_emu & 'h00FF) | ((d & 'hFF) << 8);
        end else if (sz == 1) begin
            m_emu = d & 'hFFFF;
        end else begin
            m_emu = (d >> 16) & 'hFFFF;
        end
    endfunction

    task automatic idle(input string r, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({r, " idle ack"}, 32'(ack), 0);
            chk({r, " idle err"}, 32'(err), 0);
            chk({r, " idle rdata"}, rdata, 0);
            model_settle();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ctl1 = 0; m_eb1 = 0; m_eb2 = 0; m_emu = 0;
        chk("R4 reset ack", 32'(ack), 0);
        chk("R4 reset rdata", rdata, 0);
    endtask

    // one access, compared against the model on every clock until ack
    task automatic access(input string r, input bit w, input int a, input int sz, input int d);
        int  lat;
        bit  e_err;
        int  e_rd;
        lat   = (a == EMU && sz == 2) ? 6 : 3;
        e_err = model_err(w, a, sz, d);
        e_rd  = (e_err || w) ? 0 : model_read(a, sz);
        @(negedge clk);
        req = 1'b1; we = w; addr = 12'(a); size = 2'(sz); wdata = 32'(d);
        for (int c = 1; c < lat; c++) begin
            @(negedge clk);
            chk({r, " ack"}, 32'(ack), (c == lat - 1) ? 1 : 0);
            chk({r, " err"}, 32'(err), (c == lat - 1) ? 32'(e_err) : 0);
            chk({r, " rdata"}, rdata, (c == lat - 1) ? 32'(e_rd) : 0);
        end
        req = 1'b0;
        if (!e_err && w) model_write(a, sz, d);
        model_settle();
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        fwe_pin = 1'b1;
        do_reset();
        access("R7 ctl1 reset pin high", 0, 0, 0, 0);
        access("R12 ctl2 read", 0, 1, 0, 0);
        access("R11 ctl1 write all ones", 1, 0, 0, 'hFF);
        access("R11 ctl1 readback", 0, 0, 0, 0);
        access("R6 eb1 write", 1, 2, 0, 'hA5);
        access("R6 eb2 write", 1, 3, 0, 'h3C);
        access("R1 eb1 read", 0, 2, 0, 0);
        access("R1 eb2 read", 0, 3, 0, 0);
        access("R12 ctl2 write", 1, 1, 0, 'h5A);
        access("R12 ctl2 reread", 0, 1, 0, 0);
        access("R10 halfword ctl1", 0, 0, 1, 0);
        access("R10 long write eb1", 1, 2, 2, 'h11);
        access("R10 eb1 unchanged", 0, 2, 0, 0);
        access("R9 emu reset", 0, EMU, 1, 0);
        access("R9 emu half write", 1, EMU, 1, 'h1234);
        access("R1 emu hi byte", 0, EMU, 0, 0);
        access("R1 emu lo byte write", 1, EMU + 1, 0, 'hAB);
        access("R3 emu long read", 0, EMU, 2, 0);
        access("R10 emu long bad low", 1, EMU, 2, 'hBEEF0001);
        access("R3 emu unchanged", 0, EMU, 2, 0);
        access("R3 emu long write", 1, EMU, 2, 'hC0DE0000);
        access("R9 emu half read", 0, EMU, 1, 0);
        access("R10 unmapped", 0, 'h100, 0, 0);
        access("R10 half at emu+1", 0, EMU + 1, 1, 0);
        access("R10 reserved size", 0, EMU, 3, 0);
        idle("R4", 2);
        // R4: hold req across ack; bench sees only one ack
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 12'd0; size = 2'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R4 held ack", 32'(ack), 1);
        @(negedge clk);
        chk("R4 held no second ack", 32'(ack), 0);
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R4 held still quiet", 32'(ack), 0);
        // R5: disabled-ROM mode
        rom_off = 1'b1;
        access("R5 ctl1 reads zero", 0, 0, 0, 0);
        access("R5 eb1 write dropped", 1, 2, 0, 'h00);
        access("R5 ctl1 write dropped", 1, 0, 0, 'h00);
        access("R9 emu write in rom_off", 1, EMU, 1, 'h0F0F);
        rom_off = 1'b0;
        access("R5 eb1 kept", 0, 2, 0, 0);
        access("R5 ctl1 kept", 0, 0, 0, 0);
        access("R9 emu after rom_off", 0, EMU, 1, 0);
        // R8: clear software enable, then restore
        access("R8 clear swe", 1, 0, 0, 'h00);
        access("R8 eb1 zero", 0, 2, 0, 0);
        access("R8 set swe", 1, 0, 0, 'h40);
        access("R8 eb1 stays cleared", 0, 2, 0, 0);
        access("R8 eb2 stays cleared", 0, 3, 0, 0);
        access("R8 eb2 rewrite", 1, 3, 0, 'h77);
        access("R8 eb2 readback", 0, 3, 0, 0);
        // R6/R7: pin low
        fwe_pin = 1'b0;
        idle("R8", 1);
        access("R7 ctl1 pin low", 0, 0, 0, 0);
        access("R6 ctl1 write blocked", 1, 0, 0, 'h05);
        access("R6 ctl1 unchanged", 0, 0, 0, 0);
        access("R8 eb2 pin low", 0, 3, 0, 0);
        access("R9 emu write pin low", 1, EMU, 0, 'h99);
        access("R9 emu read pin low", 0, EMU, 1, 0);
        fwe_pin = 1'b1;
        access("R8 eb2 after pin back", 0, 3, 0, 0);
        fwe_pin = 1'b0;
        do_reset();
        access("R7 ctl1 reset pin low", 0, 0, 0, 0);
        access("R9 emu reset again", 0, EMU, 1, 0);
        idle("R4", 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule